// File: doc/BRIEF.md
# YUV420 Plane Address Generator

This block turns a frame-buffer description into the start addresses of the planes that a display write engine fills. Its inputs are an output format code, a destination base address, a luma line pitch in bytes, a frame width and a clipped frame height. On a load strobe it checks these values and registers the luma base address, the first chroma plane address, the second chroma plane address with its valid qualifier, and the chroma line pitch. When the configuration is bad it raises an error flag and keeps the last good result.

Two 4:2:0 layouts get chroma addresses. In the three-plane layout each chroma line is half the luma pitch, padded up to a multiple of 16 bytes, and the two chroma planes follow the luma plane back to back. In the two-plane layout the interleaved chroma plane follows the luma plane, and its pitch is half the luma pitch with no padding. Every other accepted format only needs the luma address, so its chroma outputs read zero.

A four-state machine records the layout of the last accepted load. The states are EMPTY (after reset, nothing loaded yet), PACKED (luma only), SEMI (two planes) and PLANAR (three planes). There are three kinds of transition. RESET goes to EMPTY. ACCEPT, a valid load, goes from any state to the state of the loaded format. REJECT, an invalid load, leaves the state as it is. The qualifier of the second chroma address is high only in PLANAR.

Top module: `yuv_plane_addr`

## Requirements
- R1: After reset all address and pitch outputs, the second chroma valid qualifier and the error flag are 0.
- R2: Outputs change only on the clock edge where the load strobe is sampled high, and are visible from that edge. Without a load every output keeps its value.
- R3: For every accepted load the luma output equals the base address. For codes 0x08 and 0x0C the first chroma output equals base + pitch × height.
- R4: For code 0x08 (three-plane) the chroma pitch is floor(pitch/2) rounded up to the next multiple of 16.
- R5: For code 0x08 the second chroma output equals the first chroma output + chroma pitch × floor(height/2), and the valid qualifier is 1.
- R6: For code 0x0C (two-plane) the chroma pitch is floor(pitch/2). The second chroma output is 0 and its qualifier is 0.
- R7: For accepted codes 0x00 to 0x07 the first and second chroma outputs, the chroma pitch and the qualifier are all 0.
- R8: A load with a code above 0x08 other than 0x0C sets the error flag and leaves all other outputs unchanged.
- R9: A load with a zero base address, zero width or zero height sets the error flag and leaves all other outputs unchanged.
- R10: A load whose produced chroma address would exceed 32 bits (first chroma for 0x08 and 0x0C, second chroma for 0x08) sets the error flag and leaves all other outputs unchanged.
- R11: The error flag stays set through later cycles and later rejected loads. The next accepted load clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load strobe for the configuration inputs |
| fmt | input | 8 | Output format code |
| base | input | 32 | Destination base address |
| pitch | input | 16 | Luma line pitch in bytes |
| width | input | 16 | Frame width in pixels |
| height | input | 16 | Clipped frame height in lines |
| luma_addr | output | 32 | Luma plane start address |
| cb_addr | output | 32 | First chroma plane start address |
| cr_addr | output | 32 | Second chroma plane start address |
| cr_valid | output | 1 | Second chroma address is meaningful |
| c_pitch | output | 16 | Chroma line pitch in bytes |
| param_err | output | 1 | Last load was rejected |

## Verification
A wrong layout state shows at the ports on the first cycle after the load. It appears as a qualifier that does not match the format code, or as a second chroma address that should be zero but is not. A wrong error register shows either as a flag that does not follow a rejected load one cycle later, or as address outputs that moved when they should have held. The bench therefore checks every output on the cycle right after each load. It also puts accepted and rejected loads next to each other, so that a result held by mistake or overwritten by mistake differs from the expected value at once.

// File: rtl/yuv_plane_addr_pkg.sv
package yuv_plane_addr_pkg;
    typedef enum logic [1:0] {
        CLS_PACKED = 2'd0,
        CLS_SEMI   = 2'd1,
        CLS_PLANAR = 2'd2
    } fmt_cls_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_PACKED = 2'd1,
        ST_SEMI   = 2'd2,
        ST_PLANAR = 2'd3
    } lay_state_e;

    localparam int unsigned CODE_PLANAR  = 8;
    localparam int unsigned CODE_SEMI    = 12;
    localparam int unsigned CODE_MAX_LIN = 8;
endpackage

// File: rtl/yuv_fmt_classify.sv
module yuv_fmt_classify
    import yuv_plane_addr_pkg::*;
#(
    parameter int FMT_W = 8
) (
    input  logic [FMT_W-1:0] fmt,
    output logic             fmt_ok,
    output fmt_cls_e         cls
);
    localparam logic [FMT_W-1:0] C_PLANAR = FMT_W'(CODE_PLANAR);
    localparam logic [FMT_W-1:0] C_SEMI   = FMT_W'(CODE_SEMI);
    localparam logic [FMT_W-1:0] C_MAXLIN = FMT_W'(CODE_MAX_LIN);

    always_comb begin
        fmt_ok = (fmt <= C_MAXLIN) || (fmt == C_SEMI);
        if (fmt == C_PLANAR)
            cls = CLS_PLANAR;
        else if (fmt == C_SEMI)
            cls = CLS_SEMI;
        else
            cls = CLS_PACKED;
    end
endmodule

// File: rtl/yuv_plane_math.sv
module yuv_plane_math #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16,
    parameter int ALIGN  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DIM_W-1:0]  pitch,
    input  logic [DIM_W-1:0]  height,
    input  logic              planar,
    output logic [ADDR_W-1:0] cb_addr,
    output logic [ADDR_W-1:0] cr_addr,
    output logic [DIM_W-1:0]  c_pitch,
    output logic              ovf_cb,
    output logic              ovf_cr
);
    localparam int PROD_W = 2 * DIM_W;
    localparam int SUM_W  = ((ADDR_W > PROD_W) ? ADDR_W : PROD_W) + 2;
    localparam logic [DIM_W:0]   ALIGN_M1 = (DIM_W+1)'(ALIGN - 1);
    localparam logic [DIM_W-1:0] ALIGN_MASK = ~DIM_W'(ALIGN - 1);

    logic [DIM_W-1:0]  half_p;
    logic [DIM_W:0]    padded;
    logic [DIM_W-1:0]  aligned_p;
    logic [DIM_W-1:0]  half_h;
    logic [PROD_W-1:0] luma_sz;
    logic [PROD_W-1:0] chroma_sz;
    logic [SUM_W-1:0]  cb_full;
    logic [SUM_W-1:0]  cr_full;

    always_comb begin
        half_p    = pitch >> 1;
        half_h    = height >> 1;
        padded    = {1'b0, half_p} + ALIGN_M1;
        aligned_p = padded[DIM_W-1:0] & ALIGN_MASK;
        c_pitch   = planar ? aligned_p : half_p;
        luma_sz   = PROD_W'(pitch) * PROD_W'(height);
        chroma_sz = PROD_W'(c_pitch) * PROD_W'(half_h);
        cb_full   = SUM_W'(base) + SUM_W'(luma_sz);
        cr_full   = cb_full + SUM_W'(chroma_sz);
        cb_addr   = cb_full[ADDR_W-1:0];
        cr_addr   = cr_full[ADDR_W-1:0];
        ovf_cb    = |cb_full[SUM_W-1:ADDR_W];
        ovf_cr    = |cr_full[SUM_W-1:ADDR_W];
    end
endmodule

// File: rtl/yuv_plane_addr.sv
module yuv_plane_addr
    import yuv_plane_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16,
    parameter int FMT_W  = 8,
    parameter int ALIGN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FMT_W-1:0]  fmt,
    input  logic [ADDR_W-1:0] base,
    input  logic [DIM_W-1:0]  pitch,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    output logic [ADDR_W-1:0] luma_addr,
    output logic [ADDR_W-1:0] cb_addr,
    output logic [ADDR_W-1:0] cr_addr,
    output logic              cr_valid,
    output logic [DIM_W-1:0]  c_pitch,
    output logic              param_err
);
    fmt_cls_e          cls;
    logic              fmt_ok;
    logic              is_planar;
    logic [ADDR_W-1:0] cb_n;
    logic [ADDR_W-1:0] cr_n;
    logic [DIM_W-1:0]  cp_n;
    logic              ovf_cb;
    logic              ovf_cr;
    logic              sizes_ok;
    logic              range_ok;
    logic              accept;
    lay_state_e        state_q;
    lay_state_e        state_d;

    yuv_fmt_classify #(.FMT_W(FMT_W)) u_cls (
        .fmt    (fmt),
        .fmt_ok (fmt_ok),
        .cls    (cls)
    );

    assign is_planar = (cls == CLS_PLANAR);

    yuv_plane_math #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .ALIGN(ALIGN)) u_math (
        .base    (base),
        .pitch   (pitch),
        .height  (height),
        .planar  (is_planar),
        .cb_addr (cb_n),
        .cr_addr (cr_n),
        .c_pitch (cp_n),
        .ovf_cb  (ovf_cb),
        .ovf_cr  (ovf_cr)
    );

    always_comb begin
        sizes_ok = (base != '0) && (width != '0) && (height != '0);
        unique case (cls)
            CLS_PLANAR: range_ok = !ovf_cb && !ovf_cr;
            CLS_SEMI:   range_ok = !ovf_cb;
            default:    range_ok = 1'b1;
        endcase
        accept = fmt_ok && sizes_ok && range_ok;
    end

    // Next-state logic: ACCEPT moves to the class of the loaded format,
    // REJECT and idle cycles keep the current layout.
    always_comb begin
        state_d = state_q;
        if (load && accept) begin
            unique case (cls)
                CLS_PLANAR: state_d = ST_PLANAR;
                CLS_SEMI:   state_d = ST_SEMI;
                default:    state_d = ST_PACKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            luma_addr <= '0;
            cb_addr   <= '0;
            cr_addr   <= '0;
            c_pitch   <= '0;
            param_err <= 1'b0;
        end else if (load) begin
            if (accept) begin
                param_err <= 1'b0;
                luma_addr <= base;
                unique case (cls)
                    CLS_PLANAR: begin
                        cb_addr <= cb_n;
                        cr_addr <= cr_n;
                        c_pitch <= cp_n;
                    end
                    CLS_SEMI: begin
                        cb_addr <= cb_n;
                        cr_addr <= '0;
                        c_pitch <= cp_n;
                    end
                    default: begin
                        cb_addr <= '0;
                        cr_addr <= '0;
                        c_pitch <= '0;
                    end
                endcase
            end else begin
                param_err <= 1'b1;
            end
        end
    end

    assign cr_valid = (state_q == ST_PLANAR);
endmodule

// File: rtl/yuv_plane_addr_chk.sv
module yuv_plane_addr_chk #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16,
    parameter int FMT_W  = 8,
    parameter int ALIGN  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic [FMT_W-1:0]  fmt,
    input logic [ADDR_W-1:0] base,
    input logic [DIM_W-1:0]  pitch,
    input logic [DIM_W-1:0]  width,
    input logic [DIM_W-1:0]  height,
    input logic [ADDR_W-1:0] luma_addr,
    input logic [ADDR_W-1:0] cb_addr,
    input logic [ADDR_W-1:0] cr_addr,
    input logic              cr_valid,
    input logic [DIM_W-1:0]  c_pitch,
    input logic              param_err
);
    localparam logic [FMT_W-1:0] C_MAXLIN = FMT_W'(8);
    localparam logic [FMT_W-1:0] C_SEMI   = FMT_W'(12);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(luma_addr) && $stable(cb_addr) && $stable(cr_addr)
                   && $stable(c_pitch) && $stable(param_err) && $stable(cr_valid)));

    p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> ((c_pitch % DIM_W'(ALIGN)) == '0));

    p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> ((cr_addr >= cb_addr) && (cb_addr >= luma_addr)));

    p_nocr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_valid |-> (cr_addr == '0));

    p_badfmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (fmt > C_MAXLIN) && (fmt != C_SEMI))
        |=> (param_err && $stable(luma_addr) && $stable(cb_addr)));

    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ((base == '0) || (width == '0) || (height == '0)))
        |=> (param_err && $stable(luma_addr)));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(param_err) |-> $past(load));
endmodule

bind yuv_plane_addr yuv_plane_addr_chk #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .FMT_W(FMT_W), .ALIGN(ALIGN)
) u_chk (.*);

// File: tb/yuv_plane_addr_tb.sv
module yuv_plane_addr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [7:0]  fmt = '0;
    logic [31:0] base = '0;
    logic [15:0] pitch = '0;
    logic [15:0] width = '0;
    logic [15:0] height = '0;
    logic [31:0] luma_addr, cb_addr, cr_addr;
    logic        cr_valid;
    logic [15:0] c_pitch;
    logic        param_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    longint e_luma = 0, e_cb = 0, e_cr = 0, e_cp = 0;
    bit     e_crv = 0, e_err = 0;

    always #5 clk = ~clk;

    yuv_plane_addr u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .fmt(fmt), .base(base),
        .pitch(pitch), .width(width), .height(height),
        .luma_addr(luma_addr), .cb_addr(cb_addr), .cr_addr(cr_addr),
        .cr_valid(cr_valid), .c_pitch(c_pitch), .param_err(param_err)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "luma_addr", longint'(luma_addr), e_luma);
        check(req, "cb_addr", longint'(cb_addr), e_cb);
        check(req, "cr_addr", longint'(cr_addr), e_cr);
        check(req, "c_pitch", longint'(c_pitch), e_cp);
        check(req, "cr_valid", longint'(cr_valid), longint'(e_crv));
        check(req, "param_err", longint'(param_err), longint'(e_err));
    endtask

    // Reference model built from the requirements
    task automatic model(int f, longint b, longint p, longint w, longint h);
        longint cb, cr, cp, cs;
        bit ok;
        ok = ((f <= 8) || (f == 12)) && (b != 0) && (w != 0) && (h != 0);
        cb = b + p * h;
        cp = (f == 8) ? (((p / 2) + 15) / 16) * 16 : p / 2;
        cs = cp * (h / 2);
        cr = cb + cs;
        if (((f == 8) || (f == 12)) && (cb >= 64'h1_0000_0000)) ok = 0;
        if ((f == 8) && (cr >= 64'h1_0000_0000)) ok = 0;
        if (!ok) begin
            e_err = 1;
        end else begin
            e_err = 0;
            e_luma = b;
            if (f == 8) begin
                e_cb = cb; e_cr = cr; e_cp = cp; e_crv = 1;
            end else if (f == 12) begin
                e_cb = cb; e_cr = 0; e_cp = cp; e_crv = 0;
            end else begin
                e_cb = 0; e_cr = 0; e_cp = 0; e_crv = 0;
            end
        end
    endtask

    task automatic do_load(string req, int f, longint b, longint p, longint w, longint h);
        @(negedge clk);
        fmt = 8'(f); base = 32'(b); pitch = 16'(p); width = 16'(w); height = 16'(h);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        model(f, b, p, w, h);
        check_all(req);
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_planar();
        do_load("R3", 8, 64'h1000_0000, 1080, 1080, 1920);
        check("R4", "pitch 1080", longint'(c_pitch), 544);
        check("R5", "cr", longint'(cr_addr), 64'h1027_9C00);
        do_load("R4", 8, 64'h2000_0000, 100, 100, 40);
        check("R4", "pitch 100", longint'(c_pitch), 64);
        do_load("R5", 8, 64'h0000_1000, 64, 64, 7);
        check("R4", "pitch 64 no pad", longint'(c_pitch), 32);
    endtask

    task automatic t_semi();
        do_load("R6", 12, 64'h3000_0000, 1081, 1080, 1920);
        check("R6", "pitch 1081", longint'(c_pitch), 540);
    endtask

    task automatic t_packed();
        do_load("R7", 3, 64'h4000_0000, 2880, 720, 1280);
        do_load("R7", 6, 64'h4100_0000, 720, 720, 1280);
    endtask

    task automatic t_hold();
        do_load("R2", 8, 64'h5000_0000, 640, 640, 480);
        @(negedge clk);
        fmt = 8'd12; base = 32'h6000_0000; pitch = 16'd32; height = 16'd10;
        repeat (3) @(negedge clk);
        check_all("R2");
    endtask

    task automatic t_badfmt();
        do_load("R8", 9, 64'h7000_0000, 64, 64, 64);
        do_load("R8", 13, 64'h7000_0000, 64, 64, 64);
        do_load("R8", 255, 64'h7000_0000, 64, 64, 64);
        repeat (2) @(negedge clk);
        check("R11", "err sticky", longint'(param_err), 1);
        do_load("R11", 12, 64'h7100_0000, 64, 64, 64);
        check("R11", "err cleared", longint'(param_err), 0);
    endtask

    task automatic t_zero();
        do_load("R9", 8, 0, 64, 64, 64);
        do_load("R9", 8, 64'h100, 64, 0, 64);
        do_load("R9", 12, 64'h100, 64, 64, 0);
        do_load("R9", 1, 64'h8000_0000, 64, 64, 64);
    endtask

    task automatic t_ovf();
        do_load("R10", 8, 64'hFFFF_0000, 4096, 4096, 4096);
        do_load("R3", 4, 64'h9000_0000, 64, 64, 64);
        do_load("R10", 8, 64'hFFF7_0000, 512, 512, 1024);
        check("R10", "cr ovf err", longint'(param_err), 1);
        do_load("R10", 12, 64'hFFF7_0000, 512, 512, 1024);
        check("R10", "semi fits", longint'(cb_addr), 64'hFFFF_0000);
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_planar();
        t_semi();
        t_packed();
        t_hold();
        t_badfmt();
        t_zero();
        t_ovf();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule